// File: doc/BRIEF.md
# Fault Status and Alert Controller

This block gathers fault indications from temperature, fan and supply monitors into two sticky status registers and drives an active-low, open-drain style alert line toward a system management bus host. Every status bit follows a level input that is high while its fault is present. Once a bit is set it stays set until a host read of its register finds the fault gone. The serial bus engine sits outside this block. It supplies a one-cycle read strobe per register and a strobe for each alert-response-address query.

Bits in register A, and bits 4..0 of register B, can pull the alert line low. The top three bits of register B record supply power-good loss, a thermal-trip event and a hardware shutdown. These are kept for the host to read but never raise the alert. An alert-response query is answered while the alert is active and leaves the alert asserted. Only clearing the status bits releases it.

Top module: `fault_alert_ctl`

## Requirements
- R1: After reset, status_a and status_b are 0 and alert_n is 1.
- R2: A status bit becomes 1 on the clock edge at which its fault input is 1. It stays 1 on later edges without a read, even after the fault input returns to 0.
- R3: On an edge with rd_a (rd_b) high, each bit of status_a (status_b) whose fault input is 0 clears, and each bit whose fault input is 1 stays set.
- R4: A read strobe for one register has no effect on the other register.
- R5: A fault input that rises in the same cycle as the read of its register leaves its bit set after that edge.
- R6: status_b[7] is the power-good bit. It is set on an edge where pwr_ok is 0, and its fault condition is pwr_ok being 0.
- R7: alert_n is 0 exactly when status_a is nonzero or any of status_b[4:0] is set. status_b[7:5] (power-good, thermal-trip, shutdown; fault inputs flt_b[6:5] and pwr_ok) never drive alert_n low.
- R8: ara_ack is 1 in a cycle where ara_qry is 1 and alert_n is 0, and 0 otherwise. A query changes neither the status registers nor alert_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_a | input | 8 | Fault condition levels for register A |
| flt_b | input | 7 | Fault condition levels for status_b[6:0] |
| pwr_ok | input | 1 | Supply power-good, low means fault |
| rd_a | input | 1 | One-cycle read strobe of register A |
| rd_b | input | 1 | One-cycle read strobe of register B |
| ara_qry | input | 1 | Alert-response-address query strobe |
| status_a | output | 8 | Status register A |
| status_b | output | 8 | Status register B |
| alert_n | output | 1 | Active-low alert |
| ara_ack | output | 1 | Query answered because alert is active |

## Verification
A read strobe and a fault input can land on the same edge. In that case the set must win and the read must still clear the neighbouring bits whose faults have gone. A query can also coincide with an active alert and with reads. Directed steps drive a read together with a newly raised fault and check the exact bit pattern after the edge. A long pseudo-random sweep then mixes fault levels, reads of both registers and queries every cycle, and compares each cycle against an arithmetic model built from the requirements.

// File: rtl/fault_alert_ctl.sv
module fault_alert_ctl #(
  parameter int NA = 8,
  parameter int NB = 8,
  parameter logic [NB-1:0] QUIET_B = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] flt_a,
  input  logic [NB-2:0] flt_b,
  input  logic          pwr_ok,
  input  logic          rd_a,
  input  logic          rd_b,
  input  logic          ara_qry,
  output logic [NA-1:0] status_a,
  output logic [NB-1:0] status_b,
  output logic          alert_n,
  output logic          ara_ack
);
  logic [NB-1:0] cond_b;
  logic [NA-1:0] keep_a;
  logic [NB-1:0] keep_b;
  logic          alert_any;

  assign cond_b = {~pwr_ok, flt_b};
  assign keep_a = rd_a ? (status_a & flt_a) : status_a;
  assign keep_b = rd_b ? (status_b & cond_b) : status_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_a <= '0;
      status_b <= '0;
    end else begin
      status_a <= keep_a | flt_a;
      status_b <= keep_b | cond_b;
    end
  end

  assign alert_any = (|status_a) | (|(status_b & ~QUIET_B));
  assign alert_n   = ~alert_any;
  assign ara_ack   = ara_qry & alert_any;
endmodule

// File: rtl/fault_alert_ctl_chk.sv
module fault_alert_ctl_chk #(
  parameter int NA = 8,
  parameter int NB = 8,
  parameter logic [NB-1:0] QUIET_B = 8'hE0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NA-1:0] flt_a,
  input logic [NB-2:0] flt_b,
  input logic          pwr_ok,
  input logic          rd_a,
  input logic          rd_b,
  input logic          ara_qry,
  input logic [NA-1:0] status_a,
  input logic [NB-1:0] status_b,
  input logic          alert_n,
  input logic          ara_ack
);
  a_r2_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a |=> ((status_a & $past(status_a)) == $past(status_a)));
  a_r2_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_a & $past(flt_a)) == $past(flt_a)));
  a_r4_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_b |=> ((status_b & $past(status_b)) == $past(status_b)));
  a_r6_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> status_b[NB-1]);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_a == '0 && (status_b & ~QUIET_B) == '0) |-> alert_n);
  a_r8_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_qry && !alert_n && !rd_a && !rd_b) |=> !alert_n);
  a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    alert_n |-> !ara_ack);
endmodule

bind fault_alert_ctl fault_alert_ctl_chk #(.NA(NA), .NB(NB), .QUIET_B(QUIET_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_a(flt_a), .flt_b(flt_b), .pwr_ok(pwr_ok),
  .rd_a(rd_a), .rd_b(rd_b), .ara_qry(ara_qry), .status_a(status_a),
  .status_b(status_b), .alert_n(alert_n), .ara_ack(ara_ack));

// File: tb/sim_fault_alert_ctl.sv
`timescale 1ns/1ps
module sim_fault_alert_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] flt_a = '0;
  logic [6:0] flt_b = '0;
  logic       pwr_ok = 1'b1;
  logic       rd_a = 1'b0, rd_b = 1'b0, ara_qry = 1'b0;
  logic [7:0] status_a, status_b;
  logic       alert_n, ara_ack;

  int checks = 0, failures = 0;
  logic [7:0] ma = '0, mb = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  fault_alert_ctl u0 (
    .clk(clk), .rst_n(rst_n), .flt_a(flt_a), .flt_b(flt_b), .pwr_ok(pwr_ok),
    .rd_a(rd_a), .rd_b(rd_b), .ara_qry(ara_qry), .status_a(status_a),
    .status_b(status_b), .alert_n(alert_n), .ara_ack(ara_ack));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic exp_alert_n();
    return !((ma != 8'h00) || ((mb & 8'h1F) != 8'h00));
  endfunction

  task automatic step(input logic [7:0] fa, input logic [6:0] fb, input logic pok,
                      input logic ra, input logic rb, input logic q);
    logic [7:0] cb;
    flt_a = fa; flt_b = fb; pwr_ok = pok; rd_a = ra; rd_b = rb; ara_qry = q;
    #1;
    chk("R8 ara_ack", {7'd0, ara_ack}, {7'd0, q & !exp_alert_n()});
    @(posedge clk);
    cb = {~pok, fb};
    ma = (ra ? (ma & fa) : ma) | fa;
    mb = (rb ? (mb & cb) : mb) | cb;
    #5;
    chk("R2/R3/R5 status_a", status_a, ma);
    chk("R3/R4/R6 status_b", status_b, mb);
    chk("R7 alert_n", {7'd0, alert_n}, {7'd0, exp_alert_n()});
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #35;
    chk("R1 status_a reset", status_a, 8'h00);
    chk("R1 status_b reset", status_b, 8'h00);
    chk("R1 alert_n reset", {7'd0, alert_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    step(8'h05, 0, 1, 0, 0, 0);
    chk("R2 set", status_a, 8'h05);
    chk("R7 alert from A", {7'd0, alert_n}, 8'h00);
    step(8'h00, 0, 1, 0, 0, 0);
    chk("R2 sticky", status_a, 8'h05);
    step(8'h01, 0, 1, 1, 0, 0);
    chk("R3 partial clear", status_a, 8'h01);
    step(8'h00, 0, 1, 1, 0, 0);
    chk("R3 full clear", status_a, 8'h00);
    chk("R7 release", {7'd0, alert_n}, 8'h01);

    step(8'h00, 7'h01, 1, 0, 0, 0);
    step(8'h08, 7'h00, 1, 1, 0, 0);
    chk("R4 rd_a keeps B", status_b, 8'h01);
    step(8'h10, 7'h00, 1, 1, 0, 0);
    chk("R5 set wins over read", status_a, 8'h10);
    step(8'h00, 7'h00, 1, 1, 1, 0);
    chk("R4 rd_b clears B", status_b, 8'h00);

    step(8'h00, 7'h00, 0, 0, 0, 0);
    chk("R6 power bit", status_b, 8'h80);
    chk("R7 power quiet", {7'd0, alert_n}, 8'h01);
    step(8'h00, 7'h60, 1, 0, 0, 1);
    chk("R7 quiet bits", status_b, 8'hE0);
    chk("R7 quiet alert", {7'd0, alert_n}, 8'h01);
    step(8'h00, 7'h10, 1, 0, 0, 0);
    chk("R7 B4 alerts", {7'd0, alert_n}, 8'h00);
    step(8'h00, 7'h00, 1, 0, 0, 1);
    chk("R8 query keeps alert", {7'd0, alert_n}, 8'h00);
    chk("R8 query keeps status", status_b, 8'hF0);
    step(8'h00, 7'h00, 1, 0, 1, 0);
    chk("R6 power bit cleared", status_b, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(w[7:0] & lfsr[7:0] & lfsr[15:8], w[14:8] & lfsr[22:16] & lfsr[30:24],
           !(w[15] & w[16] & w[17]), w[18] & w[19], w[20] & w[21], w[22]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule